// File: doc/BRIEF.md
# Request-Acknowledge Window Checker

This block is a synthesizable protocol monitor. It watches a request line and an acknowledge line and raises a registered one-cycle violation pulse when an acknowledge fails to arrive between a minimum and a maximum number of cycles after a request. It also flags an acknowledge that has no request waiting inside that window. Each request leaves a flag in a shift register that advances by one stage per active clock. The age of a flag is its stage number, so a search over a range of stages finds the requests that are currently due.

Requests can arrive while earlier ones are still waiting. A parameter picks one of five policies for this case:

- restart: the new request replaces the waiting one.
- ignore: the new request is dropped.
- complain: the new request is reported as a violation.
- shared: every request is tracked, and one acknowledge settles all of the due requests.
- pipelined: every request is tracked, and each acknowledge settles only the oldest due request.

Further parameters set the active clock edge, the reset polarity and style, the enable polarity, and the severity attached to each report. The monitor is instantiated next to the logic it observes. It has no data path of its own.

Top module: `reqack_window_mon`

## Requirements
- R1: While reset is applied, `viol` is 0 at every clock edge and every waiting request is discarded, so an acknowledge after reset is reported as unmatched.
- R2: A request sampled at edge t with no acknowledge in the window causes `viol`=1 with `cause`=0 (late) after edge t+WIN_MAX, and never earlier.
- R3: An acknowledge sampled at edge t+d, with WIN_MIN ≤ d ≤ WIN_MAX, settles the request from edge t. That request then produces no violation.
- R4: An acknowledge that finds no request of age WIN_MIN..WIN_MAX causes `viol`=1 with `cause`=1 (unmatched) after that edge. A younger request is left waiting and can still be settled later.
- R5: In pipelined policy (POLICY=4), every request is tracked and each acknowledge settles only the oldest due request.
- R6: In shared policy (POLICY=3), every request is tracked and one acknowledge settles every request of due age.
- R7: In restart policy (POLICY=0), a request discards any waiting request and starts a new window, including one that would otherwise time out on that edge.
- R8: In ignore policy (POLICY=1), a request that arrives while another is waiting has no effect.
- R9: In complain policy (POLICY=2), a request that arrives while another is waiting is not recorded and causes `viol`=1 with `cause`=2 (reissue).
- R10: The acknowledge is handled before the request, and the request before the timeout test. When several causes occur on one edge, a single pulse reports the highest-priority one: late (0), then unmatched (1), then reissue (2).
- R11: While the enable is inactive, waiting requests keep their ages, `req` and `ack` are ignored, and no violation is raised.
- R12: `sev` is the SEV parameter (0 info, 1 warning, 2 error, 3 fatal) for causes 0 to 2. Cause 3 is produced only when an input is unknown; it then carries XSEV and the flags hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the active edge is set by CLK_FALL |
| rst_n | input | 1 | Reset; active low by default, synchronous by default |
| en | input | 1 | Monitor enable; active high by default |
| req | input | 1 | Observed request |
| ack | input | 1 | Observed acknowledge |
| viol | output | 1 | Registered one-cycle violation pulse |
| cause | output | 2 | Violation cause: 0 late, 1 unmatched, 2 reissue, 3 unknown input |
| sev | output | 2 | Severity of the reported violation |

## Verification
Every result is due exactly one active edge after the edge that samples the triggering inputs. A missing acknowledge therefore shows up after edge t+WIN_MAX for a request sampled at edge t. An unmatched acknowledge or a reissued request shows up after the edge that sampled it. The bench drives inputs on the falling edge and advances its reference model for that edge at the same time. It compares the outputs at the next falling edge, which lies half a period after the rising edge that registered them. It sweeps all five policies in parallel instances over every 4-cycle request pattern combined with every 4-cycle acknowledge pattern, then runs a long pseudo-random run with enable gaps and a reset in the middle.

// File: rtl/rqw_pkg.sv
// Shared types for the request/acknowledge window monitor.
// Assumes: cause and severity codes fit in two bits each.
package rqw_pkg;

    // Policy for a request that arrives while another is waiting.
    typedef enum logic [2:0] {
        POL_RESTART  = 3'd0,
        POL_IGNORE   = 3'd1,
        POL_COMPLAIN = 3'd2,
        POL_SHARED   = 3'd3,
        POL_PIPE     = 3'd4
    } policy_e;

    // Violation cause, listed in priority order for causes 0..2.
    typedef enum logic [1:0] {
        CAUSE_LATE    = 2'd0,
        CAUSE_STRAY   = 2'd1,
        CAUSE_REISSUE = 2'd2,
        CAUSE_UNKNOWN = 2'd3
    } cause_e;

    typedef enum logic [1:0] {
        SEV_INFO  = 2'd0,
        SEV_WARN  = 2'd1,
        SEV_ERROR = 2'd2,
        SEV_FATAL = 2'd3
    } sev_e;

    typedef enum logic [1:0] {
        RST_SYNC  = 2'd0,
        RST_ASYNC = 2'd1,
        RST_NONE  = 2'd2
    } rst_style_e;

    // One registered report.
    typedef struct packed {
        logic   fire;
        cause_e why;
        sev_e   level;
    } verdict_t;

endpackage

// File: rtl/rqw_mon_reg.sv
// Storage register whose reset behaviour is chosen at elaboration.
// Assumes: rst_i is already active high; clk_i is already edge-corrected.
module rqw_mon_reg #(
    parameter int                  W     = 8,
    parameter rqw_pkg::rst_style_e STYLE = rqw_pkg::RST_SYNC
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    if (STYLE == rqw_pkg::RST_ASYNC) begin : g_async
        // Register with a reset that acts without waiting for the clock.
        always_ff @(posedge clk_i or posedge rst_i) begin
            if (rst_i) q_o <= '0;
            else       q_o <= d_i;
        end
    end else if (STYLE == rqw_pkg::RST_SYNC) begin : g_sync
        // Register with a reset sampled on the clock edge.
        always_ff @(posedge clk_i) begin
            if (rst_i) q_o <= '0;
            else       q_o <= d_i;
        end
    end else begin : g_noreset
        // Register without reset.
        always_ff @(posedge clk_i) begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/rqw_xprobe.sv
// Detects an unknown value on any monitored input bit.
// Assumes: in two-state evaluation the output is always 0.
module rqw_xprobe #(
    parameter int W = 3
) (
    input  logic [W-1:0] sig_i,
    output logic         unknown_o
);

    // Flag any bit that is neither 0 nor 1.
    assign unknown_o = $isunknown(sig_i);

endmodule

// File: rtl/rqw_flag_window.sv
// Next-state logic of the request flag shift register for one active cycle.
// Stage k (1..WIN_MAX) holds a request sampled k edges ago.
// Order: settle on acknowledge, apply the request policy, test the
// oldest stage for a timeout, then shift and insert.
// Assumes: 1 <= WIN_MIN <= WIN_MAX and WIN_MAX >= 2.
module rqw_flag_window #(
    parameter int               WIN_MIN = 3,
    parameter int               WIN_MAX = 5,
    parameter rqw_pkg::policy_e POLICY  = rqw_pkg::POL_PIPE
) (
    input  logic [WIN_MAX:1] flags_i,
    input  logic             req_i,
    input  logic             ack_i,
    output logic [WIN_MAX:1] flags_o,
    output logic             late_o,
    output logic             stray_o,
    output logic             reissue_o
);

    // Mask of the stages whose age lies inside the acknowledge window.
    function automatic logic [WIN_MAX:1] window_mask();
        logic [WIN_MAX:1] m;
        for (int k = 1; k <= WIN_MAX; k++) m[k] = (k >= WIN_MIN);
        return m;
    endfunction

    localparam logic [WIN_MAX:1] WIN_MASK = window_mask();

    logic [WIN_MAX:1] in_win;
    logic [WIN_MAX:1] retire;
    logic [WIN_MAX:1] after_ack;
    logic [WIN_MAX:1] after_req;
    logic             pending;
    logic             insert;
    logic             wipe;

    assign in_win = flags_i & WIN_MASK;

    if (POLICY == rqw_pkg::POL_PIPE) begin : g_oldest
        logic [WIN_MAX:1] oldest;
        // Keep only the highest set stage, which is the oldest due request.
        always_comb begin
            oldest = '0;
            for (int k = 1; k <= WIN_MAX; k++) begin
                if (in_win[k]) begin
                    oldest    = '0;
                    oldest[k] = 1'b1;
                end
            end
        end
        assign retire = oldest;
    end else begin : g_all_due
        assign retire = in_win;
    end

    // Acknowledge step: settle due requests or report an unmatched acknowledge.
    always_comb begin
        stray_o   = ack_i & ~(|in_win);
        after_ack = (ack_i && (|in_win)) ? (flags_i & ~retire) : flags_i;
    end

    // Request step: apply the policy to requests that arrive while one is waiting.
    always_comb begin
        pending   = |after_ack;
        insert    = 1'b0;
        wipe      = 1'b0;
        reissue_o = 1'b0;
        if (req_i) begin
            unique case (POLICY)
                rqw_pkg::POL_RESTART: begin
                    wipe   = 1'b1;
                    insert = 1'b1;
                end
                rqw_pkg::POL_IGNORE: begin
                    insert = ~pending;
                end
                rqw_pkg::POL_COMPLAIN: begin
                    insert    = ~pending;
                    reissue_o = pending;
                end
                default: begin
                    insert = 1'b1;
                end
            endcase
        end
        after_req = wipe ? '0 : after_ack;
    end

    // Timeout test on the oldest stage, then shift by one stage and insert.
    always_comb begin
        late_o     = after_req[WIN_MAX];
        flags_o[1] = insert;
        for (int k = 2; k <= WIN_MAX; k++) flags_o[k] = after_req[k-1];
    end

endmodule

// File: rtl/reqack_window_mon.sv
// Request/acknowledge window monitor top level.
// Tracks waiting requests as ageing flags, applies an overlap policy and
// registers a one-cycle violation report with a cause and a severity.
// Assumes: 1 <= WIN_MIN <= WIN_MAX, WIN_MAX >= 2; inputs are synchronous to clk.
module reqack_window_mon #(
    parameter int                  WIN_MIN   = 3,
    parameter int                  WIN_MAX   = 5,
    parameter rqw_pkg::policy_e    POLICY    = rqw_pkg::POL_PIPE,
    parameter bit                  CLK_FALL  = 1'b0,
    parameter bit                  RST_LOW   = 1'b1,
    parameter rqw_pkg::rst_style_e RST_STYLE = rqw_pkg::RST_SYNC,
    parameter bit                  EN_LOW    = 1'b0,
    parameter rqw_pkg::sev_e       SEV       = rqw_pkg::SEV_ERROR,
    parameter rqw_pkg::sev_e       XSEV      = rqw_pkg::SEV_FATAL
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       req,
    input  logic       ack,
    output logic       viol,
    output logic [1:0] cause,
    output logic [1:0] sev
);

    localparam int VW = $bits(rqw_pkg::verdict_t);

    if (WIN_MIN < 1 || WIN_MIN > WIN_MAX || WIN_MAX < 2) begin : g_bad_window
        $error("reqack_window_mon: window bounds out of range");
    end

    logic                mon_clk;
    logic                rst_act;
    logic                en_on;
    logic                x_seen;
    logic                active;
    logic [WIN_MAX:1]    flag_q;
    logic [WIN_MAX:1]    flag_step;
    logic [WIN_MAX:1]    flag_d;
    logic                late;
    logic                stray;
    logic                reissue;
    rqw_pkg::verdict_t   verdict_d;
    rqw_pkg::verdict_t   verdict_q;

    // Normalise clock edge, reset polarity and enable polarity.
    assign mon_clk = clk ^ CLK_FALL;
    assign rst_act = (RST_STYLE == rqw_pkg::RST_NONE) ? 1'b0 : (rst_n ^ RST_LOW);
    assign en_on   = en ^ EN_LOW;
    assign active  = en_on & ~x_seen;

    rqw_xprobe #(.W(3)) u_xprobe (
        .sig_i     ({en, req, ack}),
        .unknown_o (x_seen)
    );

    rqw_flag_window #(
        .WIN_MIN (WIN_MIN),
        .WIN_MAX (WIN_MAX),
        .POLICY  (POLICY)
    ) u_window (
        .flags_i   (flag_q),
        .req_i     (req),
        .ack_i     (ack),
        .flags_o   (flag_step),
        .late_o    (late),
        .stray_o   (stray),
        .reissue_o (reissue)
    );

    // Flags advance only in an active cycle with known inputs.
    assign flag_d = active ? flag_step : flag_q;

    // Build the report: unknown input first, then late, unmatched, reissue.
    always_comb begin
        verdict_d = '0;
        if (x_seen) begin
            verdict_d.fire  = 1'b1;
            verdict_d.why   = rqw_pkg::CAUSE_UNKNOWN;
            verdict_d.level = XSEV;
        end else if (active && (late || stray || reissue)) begin
            verdict_d.fire  = 1'b1;
            verdict_d.level = SEV;
            if (late)       verdict_d.why = rqw_pkg::CAUSE_LATE;
            else if (stray) verdict_d.why = rqw_pkg::CAUSE_STRAY;
            else            verdict_d.why = rqw_pkg::CAUSE_REISSUE;
        end
    end

    rqw_mon_reg #(.W(WIN_MAX), .STYLE(RST_STYLE)) u_flag_reg (
        .clk_i (mon_clk),
        .rst_i (rst_act),
        .d_i   (flag_d),
        .q_o   (flag_q)
    );

    rqw_mon_reg #(.W(VW), .STYLE(RST_STYLE)) u_verdict_reg (
        .clk_i (mon_clk),
        .rst_i (rst_act),
        .d_i   (verdict_d),
        .q_o   (verdict_q)
    );

    assign viol  = verdict_q.fire;
    assign cause = verdict_q.why;
    assign sev   = verdict_q.level;

endmodule

// File: rtl/reqack_window_mon_chk.sv
// Property checker for the request/acknowledge window monitor, bound to it.
// Assumes: the same parameters as the bound instance.
module reqack_window_mon_chk #(
    parameter int                  WIN_MIN   = 3,
    parameter int                  WIN_MAX   = 5,
    parameter rqw_pkg::policy_e    POLICY    = rqw_pkg::POL_PIPE,
    parameter bit                  CLK_FALL  = 1'b0,
    parameter bit                  RST_LOW   = 1'b1,
    parameter rqw_pkg::rst_style_e RST_STYLE = rqw_pkg::RST_SYNC,
    parameter bit                  EN_LOW    = 1'b0,
    parameter rqw_pkg::sev_e       SEV       = rqw_pkg::SEV_ERROR
) (
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             req,
    input logic             ack,
    input logic             viol,
    input logic [1:0]       cause,
    input logic [1:0]       sev,
    input logic [WIN_MAX:1] flag_q
);

    logic             ck;
    logic             rst_act;
    logic             en_on;
    logic             known;
    logic             active;
    logic [WIN_MAX:1] due;

    assign ck      = clk ^ CLK_FALL;
    assign rst_act = (RST_STYLE == rqw_pkg::RST_NONE) ? 1'b0 : (rst_n ^ RST_LOW);
    assign en_on   = en ^ EN_LOW;
    assign known   = !$isunknown({en, req, ack});
    assign active  = en_on && known;

    // Stages whose age is inside the acknowledge window.
    always_comb begin
        for (int k = 1; k <= WIN_MAX; k++) due[k] = flag_q[k] && (k >= WIN_MIN);
    end

    if (RST_STYLE != rqw_pkg::RST_NONE) begin : g_rst_prop
        // R1: an edge under reset leaves no report and no waiting request.
        a_r1_reset_clears: assert property (@(posedge ck)
            rst_act |=> (!viol && flag_q == '0));
    end

    // R2, R10: a flag at the oldest stage with no acknowledge is reported late.
    a_r2_late_reported: assert property (@(posedge ck) disable iff (rst_act)
        (active && flag_q[WIN_MAX] && !ack && !(req && POLICY == rqw_pkg::POL_RESTART))
        |=> (viol && cause == 2'd0));

    // R4: an acknowledge with nothing due is reported as unmatched.
    a_r4_stray_reported: assert property (@(posedge ck) disable iff (rst_act)
        (active && ack && due == '0) |=> (viol && cause == 2'd1));

    // R11: an inactive enable freezes the flags and suppresses reports.
    a_r11_idle_freeze: assert property (@(posedge ck) disable iff (rst_act)
        (known && !en_on) |=> (!viol && $stable(flag_q)));

    // R12: known-input reports carry the configured severity.
    a_r12_severity_tag: assert property (@(posedge ck) disable iff (rst_act)
        (viol && cause != 2'd3) |-> (sev == SEV));

    if (POLICY == rqw_pkg::POL_RESTART || POLICY == rqw_pkg::POL_IGNORE ||
        POLICY == rqw_pkg::POL_COMPLAIN) begin : g_single
        // R7, R8, R9: single-request policies never hold two flags.
        a_r8_single_pending: assert property (@(posedge ck) disable iff (rst_act)
            $onehot0(flag_q));
    end

    if (POLICY == rqw_pkg::POL_COMPLAIN) begin : g_complain
        // R9: a request while one is waiting and unacknowledged is reported.
        a_r9_reissue_flagged: assert property (@(posedge ck) disable iff (rst_act)
            (active && req && !ack && flag_q != '0)
            |=> (viol && (cause == 2'd0 || cause == 2'd2)));
    end

endmodule

bind reqack_window_mon reqack_window_mon_chk #(
    .WIN_MIN   (WIN_MIN),
    .WIN_MAX   (WIN_MAX),
    .POLICY    (POLICY),
    .CLK_FALL  (CLK_FALL),
    .RST_LOW   (RST_LOW),
    .RST_STYLE (RST_STYLE),
    .EN_LOW    (EN_LOW),
    .SEV       (SEV)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .req    (req),
    .ack    (ack),
    .viol   (viol),
    .cause  (cause),
    .sev    (sev),
    .flag_q (flag_q)
);

// File: tb/reqack_window_mon_tb_top.sv
// Bench: one instance per policy, all fed the same stimulus, compared with
// an age-list reference model computed from the requirements.
module reqack_window_mon_tb_top;
    import rqw_pkg::*;

    localparam int LO = 3;
    localparam int HI = 5;
    localparam int NM = 5;

    logic       clk   = 1'b0;
    logic       rst_n = 1'b0;
    logic       en    = 1'b0;
    logic       req   = 1'b0;
    logic       ack   = 1'b0;
    logic       viol_w  [NM];
    logic [1:0] cause_w [NM];
    logic [1:0] sev_w   [NM];

    always #10 clk = ~clk;

    for (genvar m = 0; m < NM; m++) begin : g_mode
        reqack_window_mon #(
            .WIN_MIN (LO),
            .WIN_MAX (HI),
            .POLICY  (policy_e'(m))
        ) dut_i (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (en),
            .req   (req),
            .ack   (ack),
            .viol  (viol_w[m]),
            .cause (cause_w[m]),
            .sev   (sev_w[m])
        );
    end

    int    checks = 0;
    int    fails  = 0;
    int    age [NM][8];
    int    cnt [NM];
    bit    exp_fire  [NM];
    int    exp_cause [NM];
    string exp_tag   [NM];
    bit    exp_valid = 1'b0;
    string mtag [NM] = '{"R7", "R8", "R9", "R6", "R5"};
    logic [15:0] lf = 16'hACE1;

    task automatic check(string tag, int act, int expv, string what);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Remove every waiting request of mode m whose age is in [lo, hi].
    function automatic void drop_range(int m, int lo, int hi);
        int j = 0;
        for (int i = 0; i < cnt[m]; i++) begin
            if (age[m][i] < lo || age[m][i] > hi) begin
                age[m][j] = age[m][i];
                j++;
            end
        end
        cnt[m] = j;
    endfunction

    function automatic void drop_at(int m, int idx);
        for (int i = idx; i < cnt[m] - 1; i++) age[m][i] = age[m][i+1];
        cnt[m] = cnt[m] - 1;
    endfunction

    function automatic void add_new(int m);
        age[m][cnt[m]] = 0;
        cnt[m] = cnt[m] + 1;
    endfunction

    // Expected effect of one active edge for policy m.
    function automatic void model_step(int m, bit r, bit a, bit e);
        int late = 0;
        int stray = 0;
        int reis = 0;
        int ncause;
        if (!e) begin
            exp_fire[m] = 1'b0;
            exp_tag[m]  = "R11";
            return;
        end
        if (a) begin
            int best = -1;
            for (int i = 0; i < cnt[m]; i++)
                if (age[m][i] >= LO && age[m][i] <= HI)
                    if (best < 0 || age[m][i] > age[m][best]) best = i;
            if (best < 0)    stray = 1;
            else if (m == 4) drop_at(m, best);
            else             drop_range(m, LO, HI);
        end
        if (r) begin
            bit busy = (cnt[m] > 0);
            case (m)
                0: begin cnt[m] = 0; add_new(m); end
                1: if (!busy) add_new(m);
                2: if (busy) reis = 1; else add_new(m);
                default: add_new(m);
            endcase
        end
        for (int i = 0; i < cnt[m]; i++) if (age[m][i] == HI) late = 1;
        drop_range(m, HI, HI);
        for (int i = 0; i < cnt[m]; i++) age[m][i] = age[m][i] + 1;
        ncause       = late + stray + reis;
        exp_fire[m]  = (ncause > 0);
        exp_cause[m] = late ? 0 : (stray ? 1 : 2);
        if (ncause > 1)  exp_tag[m] = "R10";
        else if (late)   exp_tag[m] = "R2";
        else if (stray)  exp_tag[m] = "R4";
        else if (reis)   exp_tag[m] = "R9";
        else if (a)      exp_tag[m] = "R3";
        else             exp_tag[m] = mtag[m];
    endfunction

    task automatic compare();
        if (!exp_valid) return;
        for (int m = 0; m < NM; m++) begin
            check(exp_tag[m], int'(viol_w[m]), int'(exp_fire[m]),
                  $sformatf("viol policy %0d", m));
            if (exp_fire[m]) begin
                check(exp_tag[m], int'(cause_w[m]), exp_cause[m],
                      $sformatf("cause policy %0d", m));
                check("R12", int'(sev_w[m]), 2, $sformatf("sev policy %0d", m));
            end
        end
    endtask

    // Check the previous edge's results, then drive the next inputs.
    task automatic cycle(bit r, bit a, bit e);
        @(negedge clk);
        compare();
        req = r;
        ack = a;
        en  = e;
        for (int m = 0; m < NM; m++) model_step(m, r, a, e);
        exp_valid = 1'b1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        compare();
        rst_n = 1'b0;
        req   = 1'b0;
        ack   = 1'b0;
        en    = 1'b0;
        for (int n = 0; n < 2; n++) begin
            @(negedge clk);
            for (int m = 0; m < NM; m++)
                check("R1", int'(viol_w[m]), 0, $sformatf("viol in reset policy %0d", m));
        end
        for (int m = 0; m < NM; m++) begin
            cnt[m]      = 0;
            exp_fire[m] = 1'b0;
            exp_tag[m]  = "R1";
        end
        exp_valid = 1'b1;
        rst_n = 1'b1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, 1'b1);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stimulus
        do_reset();
        // R1: nothing survives reset, so a first acknowledge is unmatched.
        cycle(1'b0, 1'b1, 1'b1);
        idle(2);
        // R2, R3, R4: a single request answered after every delay 1..HI+1.
        for (int d = 1; d <= HI + 1; d++) begin
            cycle(1'b1, 1'b0, 1'b1);
            idle(d - 1);
            cycle(1'b0, 1'b1, 1'b1);
            idle(HI + 2);
        end
        // R5..R10: every request pattern over 4 cycles with every
        // acknowledge pattern over the following 4 cycles.
        for (int pat = 0; pat < 256; pat++) begin
            for (int i = 0; i < 8; i++) begin
                bit b = pat[i];
                cycle((i < 4) ? b : 1'b0, (i >= 4) ? b : 1'b0, 1'b1);
            end
            idle(HI + 2);
        end
        // R11 and all policies under mixed densities with enable gaps.
        for (int ph = 0; ph < 16; ph++) begin
            int rth = 2 + (ph % 4) * 3;
            int ath = 2 + (ph / 4) * 3;
            if (ph == 8) do_reset();
            for (int i = 0; i < 250; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                cycle(int'(lf[3:0]) < rth, int'(lf[7:4]) < ath, lf[11:8] != 4'd0);
            end
        end
        idle(HI + 2);
        @(negedge clk);
        compare();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule